// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic core of a small accumulator machine. It holds the 8-bit working register W internally. On every enabled clock edge it replaces W with the result of one operation, and it updates a small flag register at the same edge. An operation works either on W alone or on W together with an external TEMP operand. The 4-bit operation code selects it, and a 3-bit index selects the target bit for bit set and bit clear.

The flag register holds carry, zero and negative flags, which the enabled operations write. It also holds an interrupt-disable flag, which only its own set and clear inputs can change. A surrounding controller drives the operation code, the index, TEMP and a write-enable. It reads back W and the four flags on plain output ports. A load operation copies TEMP into W, so the controller can seed the accumulator.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and after it is released, W reads 0 and carry, zero, negative and interrupt-disable all read 0 until the first enabled operation or interrupt-disable input.
- R2: With write-enable high, the result appears on W and the flags after the next rising clock edge. With write-enable low, W, carry, zero and negative keep their values whatever the operation code.
- R3: Op 4'hB adds TEMP to W. Carry becomes bit 8 of the 9-bit sum.
- R4: Ops 4'hC, 4'hD and 4'hE put W AND TEMP, W OR TEMP and W XOR TEMP into W, and carry keeps its value.
- R5: Op 4'h2 adds 1 to W, and carry is set only when W was 8'hFF. Op 4'h3 subtracts 1 from W, and carry (borrow) is set only when W was 8'h00.
- R6: Op 4'h4 replaces W with its two's complement. Carry (borrow) is set exactly when W was nonzero.
- R7: Op 4'h0 clears W to 0 and op 4'h1 inverts every bit of W. Carry keeps its value for both.
- R8: Op 4'h5 sets, and op 4'h6 clears, the bit of W chosen by the bit index (0 = least significant bit). Other bits and carry keep their values.
- R9: Op 4'h7 rotates W left through carry (old carry enters bit 0, old bit 7 goes to carry). Op 4'h8 rotates right through carry (old carry enters bit 7, old bit 0 goes to carry).
- R10: Op 4'h9 shifts W left and op 4'hA shifts it right, both logically with 0 shifted in. The bit shifted out goes to carry.
- R11: After every enabled operation, zero is 1 exactly when the new W is 8'h00, and negative equals bit 7 of the new W.
- R12: The interrupt-disable flag is set by its set input and cleared by its clear input one edge later, regardless of write-enable. Set wins when both are high. ALU operations never change it.
- R13: Op 4'hF copies TEMP into W, and carry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we_i | input | 1 | Write-enable for W, carry, zero and negative |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit index for bit set and bit clear |
| temp_i | input | WIDTH (8) | TEMP operand |
| idis_set_i | input | 1 | Sets the interrupt-disable flag |
| idis_clr_i | input | 1 | Clears the interrupt-disable flag |
| w_o | output | WIDTH (8) | Current working register W |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| idis_o | output | 1 | Interrupt-disable flag |

## Verification
Every operation and every interrupt-disable pulse shows its result after exactly one rising edge. A reset release takes two further edges through the internal synchronizer before the first operation is accepted. The bench drives each stimulus on a falling edge and reads W and all flags on the following falling edge, half a period after the capturing edge. Each scenario first puts carry into a known state through increment or decrement, so that it can test whether carry is kept or replaced.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_CLR  = 4'h0,
    OP_NOT  = 4'h1,
    OP_INC  = 4'h2,
    OP_DEC  = 4'h3,
    OP_NEG  = 4'h4,
    OP_BSET = 4'h5,
    OP_BCLR = 4'h6,
    OP_ROL  = 4'h7,
    OP_ROR  = 4'h8,
    OP_SHL  = 4'h9,
    OP_SHR  = 4'hA,
    OP_ADD  = 4'hB,
    OP_AND  = 4'hC,
    OP_OR   = 4'hD,
    OP_XOR  = 4'hE,
    OP_LDT  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_LOGIC = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_SHIFT = 2'd2
  } unit_sel_e;

  function automatic unit_sel_e op_unit(input alu_op_e op);
    unit_sel_e u;
    case (op)
      OP_INC, OP_DEC, OP_NEG, OP_ADD: u = UNIT_ARITH;
      OP_ROL, OP_ROR, OP_SHL, OP_SHR: u = UNIT_SHIFT;
      default:                        u = UNIT_LOGIC;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/acc_alu_rst_sync.sv
`timescale 1ns/1ps
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] t_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] w_ext;
  logic [EXT-1:0] t_ext;
  logic [EXT-1:0] sum;

  assign w_ext = {1'b0, w_i};
  assign t_ext = {1'b0, t_i};

  // Nine-bit arithmetic: the top bit is carry on sums, borrow on differences.
  always_comb begin
    case (op_i)
      OP_INC:  sum = w_ext + EXT'(1);
      OP_DEC:  sum = w_ext - EXT'(1);
      OP_NEG:  sum = EXT'(0) - w_ext;
      OP_ADD:  sum = w_ext + t_ext;
      default: sum = w_ext;
    endcase
  end

  assign res_o   = sum[WIDTH-1:0];
  assign carry_o = sum[WIDTH];

endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] t_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] mask;

  // One-hot bit select decoded per bit position.
  for (genvar k = 0; k < WIDTH; k++) begin : g_mask
    localparam logic [IDX_W-1:0] KIDX = IDX_W'(k);
    assign mask[k] = (idx_i == KIDX);
  end

  always_comb begin
    case (op_i)
      OP_CLR:  res_o = '0;
      OP_NOT:  res_o = ~w_i;
      OP_BSET: res_o = w_i | mask;
      OP_BCLR: res_o = w_i & ~mask;
      OP_AND:  res_o = w_i & t_i;
      OP_OR:   res_o = w_i | t_i;
      OP_XOR:  res_o = w_i ^ t_i;
      OP_LDT:  res_o = t_i;
      default: res_o = w_i;
    endcase
  end

endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  always_comb begin
    case (op_i)
      OP_ROL: begin
        res_o   = {w_i[WIDTH-2:0], carry_i};
        carry_o = w_i[WIDTH-1];
      end
      OP_ROR: begin
        res_o   = {carry_i, w_i[WIDTH-1:1]};
        carry_o = w_i[0];
      end
      OP_SHL: begin
        res_o   = {w_i[WIDTH-2:0], 1'b0};
        carry_o = w_i[WIDTH-1];
      end
      OP_SHR: begin
        res_o   = {1'b0, w_i[WIDTH-1:1]};
        carry_o = w_i[0];
      end
      default: begin
        res_o   = w_i;
        carry_o = carry_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       op_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [WIDTH-1:0] temp_i,
  input  logic             idis_set_i,
  input  logic             idis_clr_i,
  output logic [WIDTH-1:0] w_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             idis_o
);

  logic             rst_sync_n;
  alu_op_e          op_e;
  unit_sel_e        unit;

  logic [WIDTH-1:0] w_q, w_d;
  logic             c_q, c_d;
  logic             z_q, z_d;
  logic             n_q, n_d;
  logic             i_q, i_d;
  logic             i_en;

  logic [WIDTH-1:0] arith_res, logic_res, shift_res;
  logic             arith_c, shift_c;

  assign op_e = alu_op_e'(op_i);

  acc_alu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i    (op_e),
    .w_i     (w_q),
    .t_i     (temp_i),
    .res_o   (arith_res),
    .carry_o (arith_c)
  );

  acc_alu_logic #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_logic (
    .op_i  (op_e),
    .w_i   (w_q),
    .t_i   (temp_i),
    .idx_i (bit_idx_i),
    .res_o (logic_res)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .op_i    (op_e),
    .w_i     (w_q),
    .carry_i (c_q),
    .res_o   (shift_res),
    .carry_o (shift_c)
  );

  // Next-state selection for W and the arithmetic flags.
  always_comb begin
    unit = op_unit(op_e);
    case (unit)
      UNIT_ARITH: begin
        w_d = arith_res;
        c_d = arith_c;
      end
      UNIT_SHIFT: begin
        w_d = shift_res;
        c_d = shift_c;
      end
      default: begin
        w_d = logic_res;
        c_d = c_q;
      end
    endcase
    z_d = (w_d == '0);
    n_d = w_d[WIDTH-1];
  end

  // Interrupt-disable: its own enable, set dominates clear.
  always_comb begin
    i_en = idis_set_i | idis_clr_i;
    i_d  = idis_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      w_q <= '0;
      c_q <= 1'b0;
      z_q <= 1'b0;
      n_q <= 1'b0;
    end else if (we_i) begin
      w_q <= w_d;
      c_q <= c_d;
      z_q <= z_d;
      n_q <= n_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      i_q <= 1'b0;
    end else if (i_en) begin
      i_q <= i_d;
    end
  end

  assign w_o     = w_q;
  assign carry_o = c_q;
  assign zero_o  = z_q;
  assign neg_o   = n_q;
  assign idis_o  = i_q;

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             we,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] temp,
  input logic             idis_set,
  input logic             idis_clr,
  input logic [WIDTH-1:0] w_q,
  input logic             flag_c,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_i
);

  logic logic_op;
  logic bit_op;
  assign logic_op = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign bit_op   = (op == OP_BSET) || (op == OP_BCLR);

  AST_IDLE_HOLD_W: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !we |=> $stable(w_q)); // R2

  AST_IDLE_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !we |=> ($stable(flag_c) && $stable(flag_z) && $stable(flag_n))); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (we && op == OP_ADD) |=> (w_q == $past(w_q + temp))); // R3

  AST_LOGIC_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (we && logic_op) |=> $stable(flag_c)); // R4

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (we && op == OP_INC) |=> (w_q == $past(w_q + WIDTH'(1)))); // R5

  AST_BITOP_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (we && bit_op) |=> $stable(flag_c)); // R8

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    we |=> (flag_z == (w_q == '0))); // R11

  AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    we |=> (flag_n == w_q[WIDTH-1])); // R11

  AST_IDIS_SET: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    idis_set |=> flag_i); // R12

  AST_IDIS_CLR: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (idis_clr && !idis_set) |=> !flag_i); // R12

  AST_IDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!idis_set && !idis_clr) |=> $stable(flag_i)); // R12

  AST_LOAD_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (we && op == OP_LDT) |=> ($stable(flag_c) && w_q == $past(temp))); // R13

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .rst_sync_n (rst_sync_n),
  .we         (we_i),
  .op         (op_i),
  .temp       (temp_i),
  .idis_set   (idis_set_i),
  .idis_clr   (idis_clr_i),
  .w_q        (w_o),
  .flag_c     (carry_o),
  .flag_z     (zero_o),
  .flag_n     (neg_o),
  .flag_i     (idis_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  import acc_alu_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       we;
  logic [3:0] op;
  logic [2:0] idx;
  logic [7:0] temp;
  logic       idis_set;
  logic       idis_clr;
  logic [7:0] w;
  logic       fc, fz, fn, fi;

  int checks = 0;
  int errors = 0;

  acc_alu u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .we_i       (we),
    .op_i       (op),
    .bit_idx_i  (idx),
    .temp_i     (temp),
    .idis_set_i (idis_set),
    .idis_clr_i (idis_clr),
    .w_o        (w),
    .carry_o    (fc),
    .zero_o     (fz),
    .neg_o      (fn),
    .idis_o     (fi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [7:0] ew,
                         input logic ec, input logic ez, input logic en);
    chk({tag, " W"}, w, ew);
    chk({tag, " carry"}, {7'd0, fc}, {7'd0, ec});
    chk({tag, " zero (R11)"}, {7'd0, fz}, {7'd0, ez});
    chk({tag, " neg (R11)"}, {7'd0, fn}, {7'd0, en});
  endtask

  // Drive on a falling edge; the result is read on the next falling edge.
  task automatic run(input logic [3:0] o, input logic [7:0] t,
                     input logic [2:0] b = 3'd0, input logic en = 1'b1);
    op = o; temp = t; idx = b; we = en;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_idis(input logic s, input logic c);
    idis_set = s; idis_clr = c;
    @(negedge clk);
    idis_set = 1'b0; idis_clr = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; we = 1'b0; op = 4'h0; idx = 3'd0; temp = 8'h00;
    idis_set = 1'b0; idis_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1 idis in reset", {7'd0, fi}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 after release", 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1 idis after release", {7'd0, fi}, 8'h00);
  endtask

  task automatic t_add;
    run(OP_LDT, 8'hF0);
    run(OP_ADD, 8'h20);
    chk_all("R3 add overflow", 8'h10, 1'b1, 1'b0, 1'b0);
    run(OP_ADD, 8'h01);
    chk_all("R3 add no carry", 8'h11, 1'b0, 1'b0, 1'b0);
    run(OP_LDT, 8'h80);
    run(OP_ADD, 8'h80);
    chk_all("R3 add to zero", 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_logic;
    run(OP_LDT, 8'hFF);
    run(OP_INC, 8'h00);
    chk_all("R5 inc wrap", 8'h00, 1'b1, 1'b1, 1'b0);
    run(OP_LDT, 8'hF0);
    chk_all("R13 load keeps carry", 8'hF0, 1'b1, 1'b0, 1'b1);
    run(OP_AND, 8'h3C);
    chk_all("R4 and", 8'h30, 1'b1, 1'b0, 1'b0);
    run(OP_OR, 8'h0F);
    chk_all("R4 or", 8'h3F, 1'b1, 1'b0, 1'b0);
    run(OP_XOR, 8'hFF);
    chk_all("R4 xor", 8'hC0, 1'b1, 1'b0, 1'b1);
    run(OP_AND, 8'h00);
    chk_all("R4 and to zero", 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_incdec;
    run(OP_LDT, 8'h7F);
    run(OP_INC, 8'h00);
    chk_all("R5 inc 7F", 8'h80, 1'b0, 1'b0, 1'b1);
    run(OP_LDT, 8'h00);
    run(OP_DEC, 8'h00);
    chk_all("R5 dec borrow", 8'hFF, 1'b1, 1'b0, 1'b1);
    run(OP_LDT, 8'h01);
    run(OP_DEC, 8'h00);
    chk_all("R5 dec to zero", 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_neg;
    run(OP_LDT, 8'h05);
    run(OP_NEG, 8'h00);
    chk_all("R6 neg 05", 8'hFB, 1'b1, 1'b0, 1'b1);
    run(OP_LDT, 8'h00);
    run(OP_NEG, 8'h00);
    chk_all("R6 neg zero", 8'h00, 1'b0, 1'b1, 1'b0);
    run(OP_LDT, 8'h80);
    run(OP_NEG, 8'h00);
    chk_all("R6 neg 80", 8'h80, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_clrnot;
    run(OP_LDT, 8'hFF);
    run(OP_INC, 8'h00);
    run(OP_LDT, 8'h5A);
    run(OP_NOT, 8'h00);
    chk_all("R7 not", 8'hA5, 1'b1, 1'b0, 1'b1);
    run(OP_CLR, 8'h77);
    chk_all("R7 clear", 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_bits;
    run(OP_LDT, 8'h01);
    run(OP_DEC, 8'h00);
    run(OP_BSET, 8'h00, 3'd7);
    chk_all("R8 set bit7", 8'h80, 1'b0, 1'b0, 1'b1);
    run(OP_BSET, 8'h00, 3'd0);
    chk_all("R8 set bit0", 8'h81, 1'b0, 1'b0, 1'b1);
    run(OP_BSET, 8'h00, 3'd3);
    chk_all("R8 set bit3", 8'h89, 1'b0, 1'b0, 1'b1);
    run(OP_BCLR, 8'h00, 3'd7);
    chk_all("R8 clear bit7", 8'h09, 1'b0, 1'b0, 1'b0);
    run(OP_BCLR, 8'h00, 3'd0);
    chk_all("R8 clear bit0", 8'h08, 1'b0, 1'b0, 1'b0);
    run(OP_BCLR, 8'h00, 3'd3);
    chk_all("R8 clear bit3", 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_rot;
    run(OP_LDT, 8'h01);
    run(OP_DEC, 8'h00);
    run(OP_LDT, 8'h81);
    run(OP_ROL, 8'h00);
    chk_all("R9 rol out", 8'h02, 1'b1, 1'b0, 1'b0);
    run(OP_ROL, 8'h00);
    chk_all("R9 rol in", 8'h05, 1'b0, 1'b0, 1'b0);
    run(OP_ROR, 8'h00);
    chk_all("R9 ror out", 8'h02, 1'b1, 1'b0, 1'b0);
    run(OP_ROR, 8'h00);
    chk_all("R9 ror in", 8'h81, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_shift;
    run(OP_LDT, 8'h81);
    run(OP_SHL, 8'h00);
    chk_all("R10 shl out", 8'h02, 1'b1, 1'b0, 1'b0);
    run(OP_SHL, 8'h00);
    chk_all("R10 shl zero in", 8'h04, 1'b0, 1'b0, 1'b0);
    run(OP_LDT, 8'h03);
    run(OP_SHR, 8'h00);
    chk_all("R10 shr out", 8'h01, 1'b1, 1'b0, 1'b0);
    run(OP_SHR, 8'h00);
    chk_all("R10 shr to zero", 8'h00, 1'b1, 1'b1, 1'b0);
    run(OP_SHR, 8'h00);
    chk_all("R10 shr empty", 8'h00, 1'b0, 1'b1, 1'b0);
    run(OP_LDT, 8'h80);
    run(OP_SHR, 8'h00);
    chk_all("R10 shr logical", 8'h40, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    run(OP_LDT, 8'hFF);
    run(OP_INC, 8'h00);
    run(OP_LDT, 8'h42);
    chk_all("R13 load", 8'h42, 1'b1, 1'b0, 1'b0);
    run(OP_ADD, 8'h55, 3'd0, 1'b0);
    chk_all("R2 idle add", 8'h42, 1'b1, 1'b0, 1'b0);
    run(OP_CLR, 8'h00, 3'd0, 1'b0);
    chk_all("R2 idle clear", 8'h42, 1'b1, 1'b0, 1'b0);
    run(OP_SHR, 8'h00, 3'd0, 1'b0);
    chk_all("R2 idle shift", 8'h42, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idis;
    chk("R12 idis starts clear", {7'd0, fi}, 8'h00);
    pulse_idis(1'b1, 1'b0);
    chk("R12 set without we", {7'd0, fi}, 8'h01);
    run(OP_LDT, 8'h00);
    run(OP_DEC, 8'h00);
    chk("R12 alu ops keep idis", {7'd0, fi}, 8'h01);
    pulse_idis(1'b1, 1'b1);
    chk("R12 set wins", {7'd0, fi}, 8'h01);
    pulse_idis(1'b0, 1'b1);
    chk("R12 clear", {7'd0, fi}, 8'h00);
    run(OP_ADD, 8'h01);
    chk("R12 alu ops keep idis clear", {7'd0, fi}, 8'h00);
    chk_all("R12 alu still works", 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_logic();
    t_incdec();
    t_neg();
    t_clrnot();
    t_bits();
    t_rot();
    t_shift();
    t_hold();
    t_idis();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule